// File: doc/BRIEF.md
# Segmented Thermometer-to-Gray Encoder

This block turns the thermometer word of a bank of clocked comparators into an 8-bit Gray-coded sample and an overflow flag. The word has 255 positions. Position 0 sits at the bottom of the ladder, and the count of contiguous ones starting from position 0 is the sampled level. A constant one is placed below position 0, which gives a 256-position vector. That vector is cut into four columns of 64 positions, and each column is reduced on its own to a 6-bit ones count and a flag. The flags then choose which column supplies the low six bits, and the index of that column supplies the top two bits.

There are three register ranks. The input word is captured on a rising clock edge. The column results are registered on the following falling edge. The Gray output is registered on the next rising edge, so a word captured at one rising edge appears on the outputs one clock later. The low bits are taken from a ones count rather than from a one-to-zero transition search, and the output is Gray coded. As a result, a single mis-set comparator inside the active column moves the binary result by exactly one step.

Top module: `therm_gray_encoder`

## Requirements
- R1: While rst_n is low at a rising clock edge, gray_o and ovf_o are 0 after that edge, whatever therm_i holds.
- R2: For a clean thermometer input with k ones (bits 0..k-1 set, 0 <= k <= 254), the output equals the Gray form of k, and ovf_o is 0.
- R3: When all 255 input bits are one, ovf_o is 1 and the code saturates at 255, so gray_o is 8'h80.
- R4: ovf_o is 1 only when all 255 input bits are one.
- R5: gray_o is b XOR (b >> 1), where b is the 8-bit binary result.
- R6: Binary bits [7:6] are the index of the highest column whose lowest padded position is one. The columns are padded positions 64c..64c+63, and padded position p is input bit p-1, with p=0 fixed at one. The counts around the column edges (63, 64, 127, 128, 191, 192) therefore encode exactly.
- R7: When a single bit below the top one of a run of k ones is cleared, and that bit lies in the same column as the top one but is not that column's lowest padded position, the binary result is k-1 and ovf_o is 0.
- R8: When a single cleared bit lies in a lower column than the top one, and is not that column's lowest padded position, the result is unchanged from the clean value k.
- R9: An input present before rising edge n is captured at edge n and shows on the outputs just after edge n+1. Just after edge n, the outputs still show the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures and outputs, falling edge registers column results |
| rst_n | input | 1 | Synchronous active-low reset |
| therm_i | input | 255 | Comparator thermometer word, bit 0 at the ladder bottom |
| gray_o | output | 8 | Registered Gray-coded sample |
| ovf_o | output | 1 | Registered overflow, set when every input bit is one |

## Verification
The contiguity assertion on the column flags assumes the input never clears the lowest padded position of a column while a higher column's flag is set. Bubbles that land exactly on a column edge are outside the one-step error guarantee. The stimulus keeps to that assumption. It sweeps every clean thermometer level, and it places single bubbles only at interior column positions, either in the top column or in a lower one. The overflow-source assertion assumes the input is held for a full clock so that the captured word and the output pair up one cycle apart, and the bench changes therm_i only just after a rising edge.

// File: rtl/therm_gray_pkg.sv
// Package: shared helpers for the thermometer-to-Gray encoder.
// Assumes codes fit in 32 bits.
package therm_gray_pkg;

    // Convert a binary value to reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/tgc_column_enc.sv
// Column encoder: counts the ones in one column of the padded thermometer
// word and registers, on the falling clock edge, the count minus one, the
// column flag (lowest position set) and a column-full bit.
// Assumes the column input is stable around the falling edge (it comes from
// a rising-edge register).
module tgc_column_enc #(
    parameter int COL_BITS = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2**COL_BITS-1:0]  col_i,
    output logic                    flag_o,
    output logic [COL_BITS-1:0]     pos_o,
    output logic                    full_o
);
    localparam int COL_W = 2**COL_BITS;

    logic [COL_BITS:0]   cnt;
    logic [COL_BITS:0]   cnt_m1;
    logic [COL_BITS-1:0] pos_d;

    // Ones count across the column; tolerant of isolated bubbles.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < COL_W; i++) begin
            cnt = cnt + (COL_BITS+1)'(col_i[i]);
        end
        cnt_m1 = cnt - 1'b1;
        pos_d  = (cnt == '0) ? '0 : cnt_m1[COL_BITS-1:0];
    end

    // Falling-edge column register with synchronous active-low reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            pos_o  <= '0;
            full_o <= 1'b0;
        end else begin
            flag_o <= col_i[0];
            pos_o  <= pos_d;
            full_o <= &col_i;
        end
    end

    // R3: a full column must report the top position with its flag set.
    assert_full_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (flag_o && (&pos_o)));

endmodule

// File: rtl/tgc_merge.sv
// Merge stage: selects the highest flagged column, forms the binary code
// {column index, position}, converts it to Gray and registers it on the
// rising edge together with the overflow flag.
// Assumes NUM_COLS is a power of two and the column results are stable at
// the rising edge (they change on the falling edge).
module tgc_merge
    import therm_gray_pkg::*;
#(
    parameter int COL_BITS = 6,
    parameter int NUM_COLS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_COLS-1:0]            flag_i,
    input  logic [NUM_COLS*COL_BITS-1:0]   pos_i,
    input  logic [NUM_COLS-1:0]            full_i,
    output logic [COL_BITS+$clog2(NUM_COLS)-1:0] gray_o,
    output logic                           ovf_o
);
    localparam int SEL_W  = $clog2(NUM_COLS);
    localparam int CODE_W = COL_BITS + SEL_W;

    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] bin;
    logic [CODE_W-1:0] gray_d;

    // Priority pick of the highest column whose flag is set; column 0 default.
    always_comb begin
        sel = '0;
        for (int c = 1; c < NUM_COLS; c++) begin
            if (flag_i[c]) sel = SEL_W'(c);
        end
        bin    = {sel, pos_i[sel*COL_BITS +: COL_BITS]};
        gray_d = CODE_W'(bin2gray(32'(bin)));
    end

    // Rising-edge output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_o <= '0;
            ovf_o  <= 1'b0;
        end else begin
            gray_o <= gray_d;
            ovf_o  <= &full_i;
        end
    end

    // R6: on an in-range input the flags fill contiguously from column 0.
    assert_flags_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i != '0) |-> (flag_i[0] && (((flag_i + 1'b1) & flag_i) == '0)));

endmodule

// File: rtl/therm_gray_encoder.sv
// Top: captures the comparator thermometer word on the rising edge, splits
// it (with a constant one padded below bit 0) into columns encoded on the
// falling edge, and merges them into a Gray-coded output one clock later.
// Assumes therm_i is settled before each rising edge.
module therm_gray_encoder #(
    parameter int COL_BITS = 6,
    parameter int NUM_COLS = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_COLS*(2**COL_BITS)-2:0]         therm_i,
    output logic [COL_BITS+$clog2(NUM_COLS)-1:0]      gray_o,
    output logic                                      ovf_o
);
    localparam int COL_W  = 2**COL_BITS;
    localparam int PAD_W  = NUM_COLS * COL_W;
    localparam int TH_W   = PAD_W - 1;
    localparam int CODE_W = COL_BITS + $clog2(NUM_COLS);

    logic [TH_W-1:0]              cap_q;
    logic [PAD_W-1:0]             padded;
    logic [NUM_COLS-1:0]          flags;
    logic [NUM_COLS-1:0]          fulls;
    logic [NUM_COLS*COL_BITS-1:0] poss;

    // Rising-edge capture of the comparator outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= therm_i;
    end

    // Constant one below the ladder bottom so an empty word encodes to 0.
    assign padded = {cap_q, 1'b1};

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        tgc_column_enc #(.COL_BITS(COL_BITS)) u_col (
            .clk    (clk),
            .rst_n  (rst_n),
            .col_i  (padded[c*COL_W +: COL_W]),
            .flag_o (flags[c]),
            .pos_o  (poss[c*COL_BITS +: COL_BITS]),
            .full_o (fulls[c])
        );
    end

    tgc_merge #(.COL_BITS(COL_BITS), .NUM_COLS(NUM_COLS)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flags),
        .pos_i  (poss),
        .full_i (fulls),
        .gray_o (gray_o),
        .ovf_o  (ovf_o)
    );

    // R1: a reset edge leaves the outputs cleared.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (gray_o == '0 && !ovf_o));

    // R3: overflow always comes with the saturated code.
    assert_ovf_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (gray_o == CODE_W'(1 << (CODE_W-1))));

    // R4: overflow only follows a captured all-ones word.
    assert_ovf_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(&cap_q));

endmodule

// File: tb/therm_gray_encoder_tb.sv
module therm_gray_encoder_tb;
    localparam int N = 255;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] therm = '0;
    logic [7:0]   gray;
    logic         ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    therm_gray_encoder u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .therm_i (therm),
        .gray_o  (gray),
        .ovf_o   (ovf)
    );

    function automatic logic [N-1:0] mk(input int k);
        logic [N-1:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] g8(input int b);
        logic [7:0] x = 8'(b);
        return x ^ (x >> 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive a word just after a rising edge; sample one full cycle later.
    task automatic apply(input logic [N-1:0] v);
        therm = v;
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates an all-ones input.
        therm = '1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 gray", int'(gray), 0);
        chk("R1 ovf", int'(ovf), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: full clean sweep, column edges included.
        for (int k = 0; k <= N; k++) begin
            apply(mk(k));
            if (k == N) begin
                chk("R3 gray", int'(gray), 8'h80);
                chk("R3 ovf", int'(ovf), 1);
            end else begin
                chk((k % 64 == 63 || k % 64 == 0) ? "R6 gray" : "R2 gray",
                    int'(gray), int'(g8(k)));
                chk("R4 ovf", int'(ovf), 0);
            end
        end
        chk("R5 gray_255", int'(gray), int'(8'hFF ^ 8'h7F));

        // R9: latency of one clock after capture.
        apply(mk(0));
        therm = mk(200);
        @(posedge clk); #1;
        chk("R9 old", int'(gray), int'(g8(0)));
        @(posedge clk); #1;
        chk("R9 new", int'(gray), int'(g8(200)));

        // R7: bubble just below the top one, same column, interior position.
        for (int k = 2; k <= N; k++) begin
            if ((k % 64) != 0 && ((k - 1) % 64) != 0) begin
                logic [N-1:0] v;
                v = mk(k);
                v[k-2] = 1'b0;
                apply(v);
                chk("R7 gray", int'(gray), int'(g8(k - 1)));
                chk("R7 ovf", int'(ovf), 0);
            end
        end

        // R8: bubble in a lower column at an interior position is ignored.
        for (int k = 70; k < N; k += 13) begin
            logic [N-1:0] v;
            int top_col;
            top_col = k / 64;
            v = mk(k);
            v[(top_col - 1) * 64 + 10] = 1'b0;
            apply(v);
            chk("R8 gray", int'(gray), int'(g8(k)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule